// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Current-Limit Chopping

This block is the digital controller for one full H-bridge that drives a brushed DC motor. It samples a power-save enable and two direction inputs. It also samples two flags from analog comparators that sit outside the block: one trips on the current limit, the other reports zero current. From these it produces four registered gate enables: upper and lower switch of leg A, and upper and lower switch of leg B.

The enable and the direction inputs are decoded into standby, off, forward, reverse and brake. When a direction is active and the current-limit flag trips, the bridge alternates between charge and a slow-decay brake on both lower switches. A both-off guard interval separates every change of configuration that could short a leg. After each entry into charge, a blanking window masks the comparator. When the bridge leaves a drive direction for off, it first turns on the opposite switch pair. This synchronous-rectified decay ends when zero current is flagged, or after a timeout.

All intervals are parameters in clock cycles. Every gate output is registered, so an input change appears at the outputs one clock after the edge that samples it.

Top module: `hb_gate_seq`

## Requirements
- R1: While the enable is low, all four gate outputs are off from the next clock, regardless of the direction inputs or the current phase of the sequence. Reset also leaves all four off.
- R2: With the enable high and the bridge idle, the direction pair {fwd_i, rev_i} is decoded one clock later. 10 turns on upper-A and lower-B. 01 turns on upper-B and lower-A. 11 turns on both lower switches. 00 turns on none.
- R3: The upper and the lower switch of the same leg are never on in the same cycle.
- R4: A change between two active configurations that turns a switch off and the other switch of its leg on passes through exactly GUARD_CYC cycles with all four gates off. This covers forward to reverse, drive to decay, decay to drive, drive to brake, and drive to rectification.
- R5: In forward or reverse, a current-limit flag seen after blanking starts this sequence: guard, then DECAY_CYC cycles with both lower switches on, then guard, then charge again in the same direction.
- R6: The current-limit flag is ignored for the first BLANK_CYC cycles of every entry into charge. If the flag is held high, charge lasts BLANK_CYC+1 cycles.
- R7: When the direction pair goes to 00 during forward or reverse, the bridge passes a guard interval and then turns on the opposite pair: upper-B and lower-A after forward. This pair stays on until the clock after the zero-current flag is seen high, and then all gates go off.
- R8: Synchronous rectification ends after at most SYNC_MAX cycles, even if the zero-current flag never rises.
- R9: Leaving brake for 00 turns all gates off on the next clock, with no rectification phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Power-save enable; low forces standby |
| fwd_i | input | 1 | Direction input, forward bit |
| rev_i | input | 1 | Direction input, reverse bit |
| ilim_i | input | 1 | Current-limit comparator flag |
| izero_i | input | 1 | Zero-current comparator flag |
| hs_a_o | output | 1 | Upper switch enable, leg A |
| hs_b_o | output | 1 | Upper switch enable, leg B |
| ls_a_o | output | 1 | Lower switch enable, leg A |
| ls_b_o | output | 1 | Lower switch enable, leg B |

## Verification
Two functions can fall in the same cycle: blanking and the current-limit trip. They meet when the comparator flag is already high on the very cycle charge begins. The bench holds the flag high from the start of forward drive and again across the return from decay. It then requires charge to last exactly BLANK_CYC+1 cycles before the guard appears. Standby can also cut into a guard interval. The bench drops the enable in that window and requires the bridge to go off with no later phase resuming.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRIVE,
    ST_GUARD,
    ST_DECAY,
    ST_SYNC,
    ST_BRAKE
  } hb_state_e;

  typedef enum logic [2:0] {
    CMD_STBY,
    CMD_OFF,
    CMD_FWD,
    CMD_REV,
    CMD_BRK
  } hb_cmd_e;

  typedef struct packed {
    logic hs_a;
    logic hs_b;
    logic ls_a;
    logic ls_b;
  } hb_gates_t;

endpackage

// File: rtl/hb_cmd_decode.sv
module hb_cmd_decode
  import hb_pkg::*;
(
  input  logic    en_i,
  input  logic    fwd_i,
  input  logic    rev_i,
  output hb_cmd_e cmd_o
);
  always_comb begin
    if (!en_i)               cmd_o = CMD_STBY;
    else if (fwd_i && rev_i) cmd_o = CMD_BRK;
    else if (fwd_i)          cmd_o = CMD_FWD;
    else if (rev_i)          cmd_o = CMD_REV;
    else                     cmd_o = CMD_OFF;
  end
endmodule

// File: rtl/hb_gate_map.sv
module hb_gate_map
  import hb_pkg::*;
(
  input  hb_state_e state_i,
  input  logic      dir_i,    // 0 forward, 1 reverse
  output hb_gates_t gates_o
);
  always_comb begin
    gates_o = '0;
    unique case (state_i)
      ST_DRIVE: begin
        gates_o.hs_a = !dir_i;
        gates_o.ls_b = !dir_i;
        gates_o.hs_b = dir_i;
        gates_o.ls_a = dir_i;
      end
      ST_SYNC: begin
        gates_o.hs_b = !dir_i;
        gates_o.ls_a = !dir_i;
        gates_o.hs_a = dir_i;
        gates_o.ls_b = dir_i;
      end
      ST_DECAY, ST_BRAKE: begin
        gates_o.ls_a = 1'b1;
        gates_o.ls_b = 1'b1;
      end
      default: gates_o = '0;
    endcase
  end
endmodule

// File: rtl/hb_interval_timer.sv
module hb_interval_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (!load_i && zero_o) |=> zero_o);
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
  import hb_pkg::*;
#(
  parameter int GUARD_CYC = 12,
  parameter int BLANK_CYC = 100,
  parameter int DECAY_CYC = 1000,
  parameter int SYNC_MAX  = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic fwd_i,
  input  logic rev_i,
  input  logic ilim_i,
  input  logic izero_i,
  output logic hs_a_o,
  output logic hs_b_o,
  output logic ls_a_o,
  output logic ls_b_o
);
  localparam int MAX_AB = (GUARD_CYC > BLANK_CYC) ? GUARD_CYC : BLANK_CYC;
  localparam int MAX_CD = (DECAY_CYC > SYNC_MAX) ? DECAY_CYC : SYNC_MAX;
  localparam int MAXV   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = $clog2(MAXV + 1);
  localparam logic [CW-1:0] LD_GUARD = CW'(GUARD_CYC - 1);
  localparam logic [CW-1:0] LD_BLANK = CW'(BLANK_CYC);
  localparam logic [CW-1:0] LD_DECAY = CW'(DECAY_CYC - 1);
  localparam logic [CW-1:0] LD_SYNC  = CW'(SYNC_MAX - 1);

  hb_cmd_e   cmd;
  hb_state_e state_q, state_d, tgt_q, tgt_d;
  logic      dir_q, dir_d, tdir_q, tdir_d;
  logic      tmr_zero, tmr_load;
  logic [CW-1:0] tmr_val;
  hb_gates_t gates_d, gates_q;
  logic      cmd_dir, cmd_new;

  hb_cmd_decode u_dec (.en_i(en_i), .fwd_i(fwd_i), .rev_i(rev_i), .cmd_o(cmd));

  assign cmd_dir = (cmd == CMD_FWD) || (cmd == CMD_REV);
  assign cmd_new = (cmd == CMD_REV);

  always_comb begin
    state_d = state_q;
    dir_d   = dir_q;
    tgt_d   = tgt_q;
    tdir_d  = tdir_q;
    if (cmd == CMD_STBY) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_dir) begin
            state_d = ST_DRIVE;
            dir_d   = cmd_new;
          end else if (cmd == CMD_BRK) begin
            state_d = ST_BRAKE;
          end
        end
        ST_DRIVE, ST_DECAY: begin
          if (cmd == CMD_OFF) begin
            state_d = ST_GUARD; tgt_d = ST_SYNC; tdir_d = dir_q;
          end else if (cmd == CMD_BRK) begin
            state_d = (state_q == ST_DECAY) ? ST_BRAKE : ST_GUARD;
            tgt_d   = ST_BRAKE;
          end else if (cmd_new != dir_q) begin
            state_d = ST_GUARD; tgt_d = ST_DRIVE; tdir_d = cmd_new;
          end else if (tmr_zero && (state_q == ST_DECAY)) begin
            state_d = ST_GUARD; tgt_d = ST_DRIVE; tdir_d = dir_q;
          end else if (tmr_zero && ilim_i) begin
            state_d = ST_GUARD; tgt_d = ST_DECAY; tdir_d = dir_q;
          end
        end
        ST_GUARD: begin
          if (tmr_zero) begin
            state_d = tgt_q;
            dir_d   = tdir_q;
          end
        end
        ST_BRAKE: begin
          if (cmd == CMD_OFF) begin
            state_d = ST_IDLE;
          end else if (cmd_dir) begin
            state_d = ST_GUARD; tgt_d = ST_DRIVE; tdir_d = cmd_new;
          end
        end
        ST_SYNC: begin
          if (cmd_dir) begin
            state_d = ST_GUARD; tgt_d = ST_DRIVE; tdir_d = cmd_new;
          end else if (cmd == CMD_BRK) begin
            state_d = ST_GUARD; tgt_d = ST_BRAKE;
          end else if (izero_i || tmr_zero) begin
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_d)
      ST_GUARD: tmr_val = LD_GUARD;
      ST_DRIVE: tmr_val = LD_BLANK;
      ST_DECAY: tmr_val = LD_DECAY;
      ST_SYNC:  tmr_val = LD_SYNC;
      default:  tmr_val = '0;
    endcase
  end
  assign tmr_load = (state_d != state_q);

  hb_interval_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  hb_gate_map u_map (.state_i(state_d), .dir_i(dir_d), .gates_o(gates_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      tgt_q   <= ST_IDLE;
      dir_q   <= 1'b0;
      tdir_q  <= 1'b0;
      gates_q <= '0;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
      dir_q   <= dir_d;
      tdir_q  <= tdir_d;
      gates_q <= gates_d;
    end
  end

  assign hs_a_o = gates_q.hs_a;
  assign hs_b_o = gates_q.hs_b;
  assign ls_a_o = gates_q.ls_a;
  assign ls_b_o = gates_q.ls_b;

  a_r3_no_shoot: assert property (@(posedge clk) disable iff (rst)
    !(hs_a_o && ls_a_o) && !(hs_b_o && ls_b_o));
  a_r1_standby: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !(hs_a_o || hs_b_o || ls_a_o || ls_b_o));
  a_r4_guard_hs_a: assert property (@(posedge clk) disable iff (rst)
    hs_a_o |=> !ls_a_o);
  a_r4_guard_ls_a: assert property (@(posedge clk) disable iff (rst)
    ls_a_o |=> !hs_a_o);
  a_r4_guard_hs_b: assert property (@(posedge clk) disable iff (rst)
    hs_b_o |=> !ls_b_o);
  a_r4_guard_ls_b: assert property (@(posedge clk) disable iff (rst)
    ls_b_o |=> !hs_b_o);
endmodule

// File: tb/hb_gate_seq_tb.sv
module hb_gate_seq_tb_top;
  localparam int G = 3;
  localparam int B = 5;
  localparam int D = 8;
  localparam int S = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_i = 0, fwd_i = 0, rev_i = 0, ilim_i = 0, izero_i = 0;
  logic hs_a_o, hs_b_o, ls_a_o, ls_b_o;
  int checks = 0;
  int errors = 0;
  int shoot = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hb_gate_seq #(.GUARD_CYC(G), .BLANK_CYC(B), .DECAY_CYC(D), .SYNC_MAX(S)) dut_i (
    .clk(clk), .rst(rst), .en_i(en_i), .fwd_i(fwd_i), .rev_i(rev_i),
    .ilim_i(ilim_i), .izero_i(izero_i),
    .hs_a_o(hs_a_o), .hs_b_o(hs_b_o), .ls_a_o(ls_a_o), .ls_b_o(ls_b_o)
  );

  // gate vector order {hs_a, hs_b, ls_a, ls_b}
  localparam logic [3:0] OFF = 4'b0000, FWD = 4'b1001, REV = 4'b0110, BRK = 4'b0011;

  always @(negedge clk)
    if (!rst && ((hs_a_o && ls_a_o) || (hs_b_o && ls_b_o))) shoot++;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drv(input logic e, input logic f, input logic r,
                     input logic il, input logic iz);
    en_i = e; fwd_i = f; rev_i = r; ilim_i = il; izero_i = iz;
  endtask

  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {hs_a_o, hs_b_o, ls_a_o, ls_b_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: gates=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic standby();
    drv(0, 0, 0, 0, 0);
    cyc(2);
  endtask

  task automatic t_reset();
    chk("R1 reset", OFF);
  endtask

  task automatic t_decode();
    standby();
    drv(1, 1, 0, 0, 0); cyc(1); chk("R2 forward", FWD);
    drv(0, 1, 0, 0, 0); cyc(1); chk("R1 standby ignores dir", OFF);
    cyc(2);             chk("R1 standby held", OFF);
    drv(1, 0, 1, 0, 0); cyc(1); chk("R2 reverse", REV);
    standby();
    drv(1, 1, 1, 0, 0); cyc(1); chk("R2 brake", BRK);
    drv(1, 0, 0, 0, 0); cyc(1); chk("R9 brake to off direct", OFF);
    cyc(3);             chk("R2 off holds", OFF);
  endtask

  task automatic t_dir_flip();
    standby();
    drv(1, 1, 0, 0, 0); cyc(4);
    drv(1, 0, 1, 0, 0);
    cyc(1); chk("R4 flip guard first", OFF);
    cyc(G - 1); chk("R4 flip guard last", OFF);
    cyc(1); chk("R4 flip reverse on", REV);
  endtask

  task automatic t_chop();
    standby();
    drv(1, 1, 0, 1, 0);
    cyc(1);     chk("R6 charge entry", FWD);
    cyc(B);     chk("R6 blank holds charge", FWD);
    cyc(1);     chk("R5 guard before decay", OFF);
    cyc(G - 1); chk("R4 guard length", OFF);
    cyc(1);     chk("R5 decay start", BRK);
    cyc(D - 1); chk("R5 decay end", BRK);
    cyc(1);     chk("R5 guard after decay", OFF);
    cyc(G - 1); chk("R4 guard length 2", OFF);
    cyc(1);     chk("R5 recharge", FWD);
    cyc(B);     chk("R6 blank after recharge", FWD);
    cyc(1);     chk("R5 second trip", OFF);
  endtask

  task automatic t_sync_timeout();
    standby();
    drv(1, 1, 0, 0, 0); cyc(7);
    drv(1, 0, 0, 0, 0);
    cyc(1);     chk("R7 guard before rectify", OFF);
    cyc(G - 1); chk("R7 guard end", OFF);
    cyc(1);     chk("R7 opposite pair", REV);
    cyc(S - 1); chk("R8 rectify last cycle", REV);
    cyc(1);     chk("R8 timeout off", OFF);
  endtask

  task automatic t_sync_zero();
    standby();
    drv(1, 0, 1, 0, 0); cyc(7);
    drv(1, 0, 0, 0, 0);
    cyc(G + 1); chk("R7 rectify after reverse", FWD);
    cyc(1);     chk("R7 rectify holds", FWD);
    drv(1, 0, 0, 0, 1);
    cyc(1);     chk("R7 zero ends rectify", OFF);
    drv(1, 0, 0, 0, 0);
  endtask

  task automatic t_brake_guard();
    standby();
    drv(1, 1, 0, 0, 0); cyc(7);
    drv(1, 1, 1, 0, 0);
    cyc(1);     chk("R4 drive to brake guard", OFF);
    cyc(G - 1); chk("R4 drive to brake guard end", OFF);
    cyc(1);     chk("R4 brake on", BRK);
  endtask

  task automatic t_stby_in_guard();
    standby();
    drv(1, 1, 0, 1, 0);
    cyc(B + 2); chk("R5 in guard", OFF);
    drv(0, 1, 0, 1, 0);
    cyc(1);     chk("R1 standby in guard", OFF);
    cyc(D + G); chk("R1 no resume", OFF);
  endtask

  task automatic finish_run();
    checks++;
    if (shoot != 0) begin
      errors++;
      $display("FAIL R3: shoot-through cycles=%0d expected=0", shoot);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    t_reset();
    t_decode();
    t_dir_flip();
    t_chop();
    t_sync_timeout();
    t_sync_zero();
    t_brake_guard();
    t_stby_in_guard();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule